// File: doc/BRIEF.md
# SMBus Host Command and Status Register Front End

This block is the software-visible face of an SMBus host controller. A simple byte-wide bus with an 8-bit offset writes and reads a small set of registers: a status byte, a control byte, a command byte, the target address with its direction bit, two data bytes, a block data byte, a packet-check byte and an auxiliary control byte. Software loads the transfer fields, then writes the control byte with its start bit set. The block then raises a one-cycle start request to a byte-level bus engine and holds the busy flag until the engine reports an outcome.

The engine returns one of three outcomes: acknowledged, not acknowledged, or arbitration lost. Each one sets its own sticky status flag, and software clears a flag by writing a one to its position. Software can also abort a running transfer through the kill bit. This drops busy at once, sets the failed flag and sends a one-cycle abort to the engine. On a successful read the engine's returned bytes are written into the data registers, so that software reads the result where it placed its write data.

Top module: `smbh_regs`

## Requirements
- R1: After reset every register reads 0x00, and engine start and abort are low.
- R2: Register offsets: status 0x00, control 0x02, command 0x03, address 0x04, data-low 0x05, data-high 0x06, block data 0x07, packet-check 0x08, auxiliary status 0x0C (reads 0), auxiliary control 0x0D. Unmapped offsets read 0.
- R3: Control layout: bit 7 packet-check enable, bit 6 start, bits 4:2 transfer kind (0 quick, 1 byte, 2 byte-data, 3 word, 4 process call, 5 block, 6 raw block), bit 1 kill. When idle, a control write with bit 6 set and bit 1 clear sets status bit 0 (busy) from the next cycle and pulses engine start for exactly one cycle. Bit 6 reads back 0. The kind and packet-check drive the engine outputs.
- R4: Outcome codes: 0 acknowledged, 1 not acknowledged, 2 arbitration lost, 3 treated as not acknowledged. On engine done while busy, busy clears on the next cycle. Status bit 1 sets for ack (bit 7 also for kinds 5 and 6), bit 2 for not acknowledged, bit 3 for arbitration lost.
- R5: Status bits 7, 4, 3, 2, 1 clear only when software writes 1 to them. A written 0 leaves them unchanged. If a flag is set in the same cycle as its clear, it stays set.
- R6: A control write with bit 1 set while busy clears busy on the next cycle, sets status bit 4 and pulses engine abort for one cycle. If engine done arrives in the same cycle, only bit 4 is set. A start written together with kill is ignored.
- R7: The address register carries the 7-bit target in bits 7:1 and the direction in bit 0 (1 = read). On an acknowledged read, data-low takes the engine's low byte for kinds 1 to 4, and data-high takes the high byte for kinds 3 and 4. Otherwise the data registers keep their values.
- R8: While busy, writes to command, address, data-low and data-high are ignored. Control kind and packet-check are held too.
- R9: Engine done while idle has no effect. A start written while busy does not pulse engine start again.
- R10: Auxiliary control keeps bits 1:0 (bit 0 hardware packet check, bit 1 block buffer mode), drives them on the engine outputs and reads 0 in the upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset (combinational) |
| eng_start | output | 1 | One-cycle transfer request |
| eng_abort | output | 1 | One-cycle abort request |
| eng_kind | output | 3 | Transfer kind |
| eng_saddr | output | 8 | Target address and direction |
| eng_cmd | output | 8 | Command byte |
| eng_wd0 | output | 8 | Data-low byte |
| eng_wd1 | output | 8 | Data-high byte |
| eng_pec | output | 1 | Packet-check enable from control |
| eng_aux | output | 2 | Auxiliary control bits |
| eng_done | input | 1 | Engine outcome valid |
| eng_res | input | 2 | Engine outcome code |
| eng_rd0 | input | 8 | Engine read low byte |
| eng_rd1 | input | 8 | Engine read high byte |

## Verification
Two pairs of events can fall in the same cycle. The first is an engine completion together with a software kill. The second is an engine completion together with a software write-one-to-clear of the flag that the completion sets. The bench drives engine done and the register write on the same falling edge, so both land on one rising edge. It then reads status: kill must win with only the failed flag, and a set must beat its clear.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

    typedef enum logic [2:0] {
        XK_QUICK  = 3'd0,
        XK_BYTE   = 3'd1,
        XK_BDATA  = 3'd2,
        XK_WORD   = 3'd3,
        XK_PCALL  = 3'd4,
        XK_BLOCK  = 3'd5,
        XK_RAWBLK = 3'd6,
        XK_RSVD   = 3'd7
    } xfer_kind_t;

    typedef enum logic [1:0] {
        ER_ACK  = 2'd0,
        ER_NACK = 2'd1,
        ER_ARB  = 2'd2,
        ER_UNK  = 2'd3
    } eng_res_t;

    localparam logic [7:0] OFS_STAT   = 8'h00;
    localparam logic [7:0] OFS_CTL    = 8'h02;
    localparam logic [7:0] OFS_CMD    = 8'h03;
    localparam logic [7:0] OFS_SADDR  = 8'h04;
    localparam logic [7:0] OFS_D0     = 8'h05;
    localparam logic [7:0] OFS_D1     = 8'h06;
    localparam logic [7:0] OFS_BLK    = 8'h07;
    localparam logic [7:0] OFS_PEC    = 8'h08;
    localparam logic [7:0] OFS_AUXSTS = 8'h0C;
    localparam logic [7:0] OFS_AUXCTL = 8'h0D;

    localparam int CB_KILL  = 1;
    localparam int CB_KLO   = 2;
    localparam int CB_KHI   = 4;
    localparam int CB_START = 6;
    localparam int CB_PEC   = 7;

    function automatic logic kind_fills_lo(xfer_kind_t k);
        return (k == XK_BYTE) || (k == XK_BDATA) || (k == XK_WORD) || (k == XK_PCALL);
    endfunction

    function automatic logic kind_fills_hi(xfer_kind_t k);
        return (k == XK_WORD) || (k == XK_PCALL);
    endfunction

    function automatic logic kind_is_block(xfer_kind_t k);
        return (k == XK_BLOCK) || (k == XK_RAWBLK);
    endfunction

endpackage

// File: rtl/smbh_status.sv
module smbh_status
    import smbh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_we,
    input  logic [4:0] clr_mask,   // {bytedone, failed, arb, noresp, done}
    input  logic       set_ok,
    input  logic       set_bdone,
    input  logic       set_nack,
    input  logic       set_arb,
    input  logic       set_fail,
    input  logic       busy,
    output logic [7:0] stat
);

    typedef struct packed {
        logic bdone;
        logic fail;
        logic arb;
        logic noresp;
        logic done;
    } flags_t;

    flags_t q, d;

    always_comb begin
        d = q;
        if (clr_we) begin
            d = flags_t'(q & ~clr_mask);
        end
        if (set_ok)    d.done   = 1'b1;
        if (set_bdone) d.bdone  = 1'b1;
        if (set_nack)  d.noresp = 1'b1;
        if (set_arb)   d.arb    = 1'b1;
        if (set_fail)  d.fail   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign stat = {q.bdone, 1'b0, 1'b0, q.fail, q.arb, q.noresp, q.done, busy};

    // R5: a set in the same cycle as its clear must survive
    a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ok && clr_we && clr_mask[0]) |=> stat[1]);

    // R5: a clear without a concurrent set empties the flag
    a_r5_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_mask[3] && !set_fail) |=> !stat[4]);

endmodule

// File: rtl/smbh_launch.sv
module smbh_launch
    import smbh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic [2:0] wr_kind,
    input  logic       wr_start,
    input  logic       wr_kill,
    input  logic       wr_pec,
    input  logic       eng_done,
    input  logic [1:0] eng_res,
    output logic       busy,
    output logic       eng_start,
    output logic       eng_abort,
    output xfer_kind_t kind,
    output logic       pec_en,
    output logic       kill_q,
    output logic       ev_ok,
    output logic       ev_nack,
    output logic       ev_arb,
    output logic       ev_fail
);

    typedef struct packed {
        logic       busy;
        logic       start_p;
        logic       abort_p;
        xfer_kind_t kind;
        logic       pec;
        logic       kill;
    } lst_t;

    lst_t q, d;
    eng_res_t res;

    assign res = eng_res_t'(eng_res);

    always_comb begin
        d         = q;
        d.start_p = 1'b0;
        d.abort_p = 1'b0;
        ev_ok     = 1'b0;
        ev_nack   = 1'b0;
        ev_arb    = 1'b0;
        ev_fail   = 1'b0;
        if (ctl_we) begin
            d.kill = wr_kill;
            if (!q.busy) begin
                d.kind = xfer_kind_t'(wr_kind);
                d.pec  = wr_pec;
            end
        end
        if (q.busy) begin
            if (ctl_we && wr_kill) begin
                d.busy    = 1'b0;
                d.abort_p = 1'b1;
                ev_fail   = 1'b1;
            end else if (eng_done) begin
                d.busy = 1'b0;
                case (res)
                    ER_ACK:  ev_ok   = 1'b1;
                    ER_ARB:  ev_arb  = 1'b1;
                    default: ev_nack = 1'b1;
                endcase
            end
        end else if (ctl_we && wr_start && !wr_kill) begin
            d.busy    = 1'b1;
            d.start_p = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{busy: 1'b0, start_p: 1'b0, abort_p: 1'b0,
                           kind: XK_QUICK, pec: 1'b0, kill: 1'b0};
        else        q <= d;
    end

    assign busy      = q.busy;
    assign eng_start = q.start_p;
    assign eng_abort = q.abort_p;
    assign kind      = q.kind;
    assign pec_en    = q.pec;
    assign kill_q    = q.kill;

    // R3: an accepted start raises busy and the request together
    a_r3_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && wr_start && !wr_kill && !busy) |=> (busy && eng_start));

    // R9: the request never lasts more than one cycle
    a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R6: kill while busy ends the transfer and signals abort
    a_r6_kill_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_we && wr_kill) |=> (!busy && eng_abort && !eng_start));

    // R4: an outcome frees the controller
    a_r4_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done) |=> !busy);

    // R4: at most one outcome per cycle
    a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_ok, ev_nack, ev_arb, ev_fail}));

endmodule

// File: rtl/smbh_regs.sv
module smbh_regs
    import smbh_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int AUX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    output logic             eng_start,
    output logic             eng_abort,
    output logic [2:0]       eng_kind,
    output logic [7:0]       eng_saddr,
    output logic [7:0]       eng_cmd,
    output logic [7:0]       eng_wd0,
    output logic [7:0]       eng_wd1,
    output logic             eng_pec,
    output logic [AUX_W-1:0] eng_aux,
    input  logic             eng_done,
    input  logic [1:0]       eng_res,
    input  logic [7:0]       eng_rd0,
    input  logic [7:0]       eng_rd1
);

    localparam int AUX_PAD = 8 - AUX_W;

    typedef struct packed {
        logic [7:0]       cmd;
        logic [7:0]       saddr;
        logic [7:0]       d0;
        logic [7:0]       d1;
        logic [7:0]       blk;
        logic [7:0]       pec;
        logic [AUX_W-1:0] aux;
    } rf_t;

    rf_t q, d;

    logic       busy, pec_en, kill_q;
    logic       ev_ok, ev_nack, ev_arb, ev_fail;
    xfer_kind_t kind;
    logic [7:0] stat;
    logic       we_stat, we_ctl;

    assign we_stat = wr_en && (addr == OFS_W'(OFS_STAT));
    assign we_ctl  = wr_en && (addr == OFS_W'(OFS_CTL));

    smbh_launch u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (we_ctl),
        .wr_kind   (wdata[CB_KHI:CB_KLO]),
        .wr_start  (wdata[CB_START]),
        .wr_kill   (wdata[CB_KILL]),
        .wr_pec    (wdata[CB_PEC]),
        .eng_done  (eng_done),
        .eng_res   (eng_res),
        .busy      (busy),
        .eng_start (eng_start),
        .eng_abort (eng_abort),
        .kind      (kind),
        .pec_en    (pec_en),
        .kill_q    (kill_q),
        .ev_ok     (ev_ok),
        .ev_nack   (ev_nack),
        .ev_arb    (ev_arb),
        .ev_fail   (ev_fail)
    );

    smbh_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_we    (we_stat),
        .clr_mask  ({wdata[7], wdata[4], wdata[3], wdata[2], wdata[1]}),
        .set_ok    (ev_ok),
        .set_bdone (ev_ok && kind_is_block(kind)),
        .set_nack  (ev_nack),
        .set_arb   (ev_arb),
        .set_fail  (ev_fail),
        .busy      (busy),
        .stat      (stat)
    );

    always_comb begin
        d = q;
        if (wr_en) begin
            if (!busy) begin
                if (addr == OFS_W'(OFS_CMD))   d.cmd   = wdata;
                if (addr == OFS_W'(OFS_SADDR)) d.saddr = wdata;
                if (addr == OFS_W'(OFS_D0))    d.d0    = wdata;
                if (addr == OFS_W'(OFS_D1))    d.d1    = wdata;
            end
            if (addr == OFS_W'(OFS_BLK))    d.blk = wdata;
            if (addr == OFS_W'(OFS_PEC))    d.pec = wdata;
            if (addr == OFS_W'(OFS_AUXCTL)) d.aux = wdata[AUX_W-1:0];
        end
        if (ev_ok && q.saddr[0]) begin
            if (kind_fills_lo(kind)) d.d0 = eng_rd0;
            if (kind_fills_hi(kind)) d.d1 = eng_rd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = 8'h00;
        case (addr)
            OFS_W'(OFS_STAT):   rdata = stat;
            OFS_W'(OFS_CTL):    rdata = {pec_en, 2'b00, kind, kill_q, 1'b0};
            OFS_W'(OFS_CMD):    rdata = q.cmd;
            OFS_W'(OFS_SADDR):  rdata = q.saddr;
            OFS_W'(OFS_D0):     rdata = q.d0;
            OFS_W'(OFS_D1):     rdata = q.d1;
            OFS_W'(OFS_BLK):    rdata = q.blk;
            OFS_W'(OFS_PEC):    rdata = q.pec;
            OFS_W'(OFS_AUXSTS): rdata = 8'h00;
            OFS_W'(OFS_AUXCTL): rdata = {{AUX_PAD{1'b0}}, q.aux};
            default:            rdata = 8'h00;
        endcase
    end

    assign eng_kind  = kind;
    assign eng_saddr = q.saddr;
    assign eng_cmd   = q.cmd;
    assign eng_wd0   = q.d0;
    assign eng_wd1   = q.d1;
    assign eng_pec   = pec_en;
    assign eng_aux   = q.aux;

    // R8: command and address are frozen while a transfer runs
    a_r8_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(eng_cmd) && $stable(eng_saddr)));

    // R7: a write-direction transfer never overwrites the data bytes
    a_r7_write_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !eng_saddr[0]) |=> ($stable(eng_wd0) && $stable(eng_wd1)));

endmodule

// File: tb/smbh_regs_bench.sv
module smbh_regs_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       eng_start, eng_abort, eng_pec;
    logic [2:0] eng_kind;
    logic [7:0] eng_saddr, eng_cmd, eng_wd0, eng_wd1;
    logic [1:0] eng_aux;
    logic       eng_done = 1'b0;
    logic [1:0] eng_res = 2'd0;
    logic [7:0] eng_rd0 = 8'h00;
    logic [7:0] eng_rd1 = 8'h00;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    smbh_regs u_smbh_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .eng_start(eng_start), .eng_abort(eng_abort),
        .eng_kind(eng_kind), .eng_saddr(eng_saddr), .eng_cmd(eng_cmd),
        .eng_wd0(eng_wd0), .eng_wd1(eng_wd1), .eng_pec(eng_pec), .eng_aux(eng_aux),
        .eng_done(eng_done), .eng_res(eng_res), .eng_rd0(eng_rd0), .eng_rd1(eng_rd1)
    );

    typedef struct packed {
        logic [2:0] kind;
        logic [7:0] sa, cmd, w0, w1;
        logic [1:0] res;
        logic [7:0] r0, r1, est, e0, e1;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{3'd2, 8'hA0, 8'h11, 8'h5A, 8'h00, 2'd0, 8'hFF, 8'hFF, 8'h02, 8'h5A, 8'h00},
        '{3'd3, 8'hA1, 8'h22, 8'h12, 8'h34, 2'd0, 8'hCD, 8'hAB, 8'h02, 8'hCD, 8'hAB},
        '{3'd1, 8'h51, 8'h33, 8'h77, 8'h66, 2'd1, 8'h99, 8'h88, 8'h04, 8'h77, 8'h66},
        '{3'd5, 8'h40, 8'h44, 8'h03, 8'h09, 2'd0, 8'hEE, 8'hEE, 8'h82, 8'h03, 8'h09},
        '{3'd0, 8'h31, 8'h55, 8'h01, 8'h02, 2'd2, 8'hAA, 8'hBB, 8'h08, 8'h01, 8'h02},
        '{3'd2, 8'h21, 8'h66, 8'h10, 8'h44, 2'd0, 8'h3C, 8'hEE, 8'h02, 8'h3C, 8'h44},
        '{3'd4, 8'h2B, 8'h77, 8'h10, 8'h20, 2'd0, 8'h55, 8'h66, 8'h02, 8'h55, 8'h66},
        '{3'd6, 8'hA3, 8'h88, 8'h04, 8'h05, 2'd0, 8'hDE, 8'hAD, 8'h82, 8'h04, 8'h05},
        '{3'd3, 8'hA4, 8'h99, 8'hC1, 8'hC2, 2'd3, 8'h11, 8'h22, 8'h04, 8'hC1, 8'hC2}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic finish_eng(input logic [1:0] r, input logic [7:0] a0, input logic [7:0] a1);
        @(negedge clk);
        eng_done = 1'b1; eng_res = r; eng_rd0 = a0; eng_rd1 = a1;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 16; a++) begin
            rd(8'(a), v);
            check("R1 reset read", v, 8'h00);
        end
        check("R1 start low", {7'd0, eng_start}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R7: table walk
        for (int i = 0; i < 9; i++) begin
            wr(8'h04, VEC[i].sa);
            wr(8'h03, VEC[i].cmd);
            wr(8'h05, VEC[i].w0);
            wr(8'h06, VEC[i].w1);
            wr(8'h02, {i[0], 1'b1, 1'b0, VEC[i].kind, 2'b00});
            check("R3 start pulse", {7'd0, eng_start}, 8'h01);
            check("R3 kind out", {5'd0, eng_kind}, {5'd0, VEC[i].kind});
            check("R3 pec out", {7'd0, eng_pec}, {7'd0, i[0]});
            check("R7 addr out", eng_saddr, VEC[i].sa);
            check("R2 cmd out", eng_cmd, VEC[i].cmd);
            rd(8'h00, v); check("R3 busy", v, 8'h01);
            rd(8'h02, v); check("R3 start self-clears", v, {i[0], 2'b00, VEC[i].kind, 2'b00});
            finish_eng(VEC[i].res, VEC[i].r0, VEC[i].r1);
            rd(8'h00, v); check("R4 outcome status", v, VEC[i].est);
            rd(8'h05, v); check("R7 data-low", v, VEC[i].e0);
            rd(8'h06, v); check("R7 data-high", v, VEC[i].e1);
            wr(8'h00, 8'hFF);
            rd(8'h00, v); check("R5 clear all", v, 8'h00);
        end

        // R2 R10: map and aux
        wr(8'h07, 8'h6B); wr(8'h08, 8'h3D); wr(8'h0D, 8'hFE); wr(8'h0C, 8'hFF);
        rd(8'h07, v); check("R2 block data", v, 8'h6B);
        rd(8'h08, v); check("R2 packet-check", v, 8'h3D);
        rd(8'h0D, v); check("R10 aux readback", v, 8'h02);
        rd(8'h0C, v); check("R2 aux status zero", v, 8'h00);
        rd(8'h01, v); check("R2 unmapped", v, 8'h00);
        check("R10 aux out", {6'd0, eng_aux}, 8'h02);
        wr(8'h0D, 8'h01);
        check("R10 aux out bit0", {6'd0, eng_aux}, 8'h01);

        // R9: done while idle is ignored
        finish_eng(2'd0, 8'hAB, 8'hCD);
        rd(8'h00, v); check("R9 idle done", v, 8'h00);

        // R8 R9 R6: writes while busy, restart while busy, kill
        wr(8'h03, 8'hC3); wr(8'h04, 8'hB1); wr(8'h05, 8'h0F); wr(8'h06, 8'hF0);
        wr(8'h02, 8'h4C);
        wr(8'h03, 8'h00); wr(8'h04, 8'h00); wr(8'h05, 8'h00); wr(8'h06, 8'h00);
        rd(8'h03, v); check("R8 cmd held", v, 8'hC3);
        rd(8'h04, v); check("R8 addr held", v, 8'hB1);
        rd(8'h05, v); check("R8 data-low held", v, 8'h0F);
        rd(8'h06, v); check("R8 data-high held", v, 8'hF0);
        wr(8'h02, 8'hD4);
        check("R9 no second start", {7'd0, eng_start}, 8'h00);
        rd(8'h02, v); check("R8 kind held", v, 8'h0C);
        wr(8'h02, 8'h0E);
        check("R6 abort pulse", {7'd0, eng_abort}, 8'h01);
        rd(8'h00, v); check("R6 failed after kill", v, 8'h10);
        rd(8'h02, v); check("R6 kill readback", v, 8'h0E);
        @(negedge clk);
        check("R6 abort one cycle", {7'd0, eng_abort}, 8'h00);
        wr(8'h02, 8'h42);
        rd(8'h00, v); check("R6 start with kill ignored", v, 8'h10);

        // R5: selective clear
        wr(8'h02, 8'h44);
        finish_eng(2'd1, 8'h00, 8'h00);
        rd(8'h00, v); check("R5 two flags", v, 8'h14);
        wr(8'h00, 8'h04);
        rd(8'h00, v); check("R5 clear one", v, 8'h10);
        wr(8'h00, 8'h00);
        rd(8'h00, v); check("R5 zero write no effect", v, 8'h10);
        wr(8'h00, 8'h10);
        rd(8'h00, v); check("R5 clear failed", v, 8'h00);

        // R6: kill and done in the same cycle
        wr(8'h02, 8'h48);
        @(negedge clk);
        eng_done = 1'b1; eng_res = 2'd0;
        wr_en = 1'b1; addr = 8'h02; wdata = 8'h0A;
        @(negedge clk);
        eng_done = 1'b0; wr_en = 1'b0;
        rd(8'h00, v); check("R6 kill beats done", v, 8'h10);
        wr(8'h00, 8'hFF); wr(8'h02, 8'h00);

        // R5: set and clear of the same flag in one cycle
        wr(8'h02, 8'h48);
        finish_eng(2'd0, 8'h00, 8'h00);
        wr(8'h02, 8'h48);
        @(negedge clk);
        eng_done = 1'b1; eng_res = 2'd0;
        wr_en = 1'b1; addr = 8'h00; wdata = 8'h02;
        @(negedge clk);
        eng_done = 1'b0; wr_en = 1'b0;
        rd(8'h00, v); check("R5 set beats clear", v, 8'h02);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule